// File: doc/BRIEF.md
# Address-Translation Control Register Pair

This block keeps the supervisor's translation configuration: a small mode register and a 64-bit page-table root register. Software reaches both through a plain CSR port: a write strobe, an address and a data word, plus a combinational read. The block makes every write legal against the features chosen by parameters. A mode register write that names an illegal combination is refused whole. A root register write that names an unsupported address-space size is refused whole, so a page number and an ASID never arrive without the size they belong to.

From the two stored registers the block decodes what a page-table walker needs: whether translation is on, the root physical page number, the address-space ID and the number of table levels. The root register is read in the short (32-bit) layout when the mode selects short translation, and in the long (64-bit) layout otherwise. This lets the short page format run on a 64-bit machine.

Top module: `xlat_ctl_csr`

## Requirements
- R1: After reset both registers read as zero, `xlat_en` is 0 and `levels` is 0.
- R2: The mode register's bits [1:0] hold the translation mode: 0 = off (root ignored), 1 = short format (32-bit addresses), 2 = long format. Bit [2] selects split instruction/data base-and-bound. All other bits read zero.
- R3: A mode write with bits [1:0] = 3, or one that names a mode the parameters leave out, leaves the mode register unchanged.
- R4: With split protection rejected alongside paging, a mode write that has bit [2] = 1 and a nonzero mode leaves the mode register unchanged. Bit [2] = 1 with mode 0 is accepted.
- R5: In long layout the root register holds the page number in bits [39:0], the ASID in bits [55:40] and the size in bits [57:56]. Size 0 means 39-bit addresses and size 1 means 48-bit addresses. Sizes 2 and 3 are always unsupported.
- R6: In long layout, a write whose size field is unsupported leaves the whole root register unchanged.
- R7: Page-number bits at or above PPN_W, ASID bits at or above ASID_W, and bits [63:58] always read as zero.
- R8: When the mode is short, a root write stores the page number in bits [21:0] and the ASID in bits [30:22], applies no size check, and clears all higher bits.
- R9: `levels` is 2 in short mode, 3 in long mode with size 0, 4 in long mode with size 1, and 0 when translation is off. In that last case `root_ppn` and `asid` are 0 as well.
- R10: No register changes without `csr_we`. A read from any address other than the two registers returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe |
| csr_addr | input | ADDR_W | Register select |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for `csr_addr` |
| xlat_en | output | 1 | Translation enabled |
| root_ppn | output | 40 | Root page number for the walker |
| asid | output | 16 | Active address-space ID |
| levels | output | 3 | Number of page-table levels |

## Verification
The bench writes a size that is not built (48-bit under the default parameters) and both reserved sizes. A design that masked fields one at a time would take on the new page number and ASID under a size it cannot walk. It then writes the reserved mode and a split-protection-plus-paging mode; a design that got this wrong would hand the walker an illegal configuration. It writes all-ones patterns to catch wide ASID, page-number or reserved bits that leak through. In short mode it writes a word with nonzero upper bits, which would be dropped or mis-sliced if the long-layout size check were applied there.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    XM_OFF   = 2'd0,
    XM_SHORT = 2'd1,
    XM_LONG  = 2'd2,
    XM_RSVD  = 2'd3
  } xmode_e;

  typedef enum logic [1:0] {
    VS_39  = 2'd0,
    VS_48  = 2'd1,
    VS_57  = 2'd2,
    VS_64  = 2'd3
  } vsize_e;

  typedef struct packed {
    logic   split;
    xmode_e mode;
  } mode_reg_t;

  localparam int LONG_PPN_W  = 40;
  localparam int LONG_ASID_W = 16;
  localparam int LONG_ASID_LO = 40;
  localparam int LONG_SIZE_LO = 56;
  localparam int SHORT_PPN_W  = 22;
  localparam int SHORT_ASID_W = 9;
endpackage

// File: rtl/xlat_mode_legal.sv
module xlat_mode_legal
  import xlat_pkg::*;
#(
  parameter bit HAS_SHORT    = 1'b1,
  parameter bit HAS_LONG     = 1'b1,
  parameter bit HAS_SPLIT    = 1'b1,
  parameter bit REJECT_SPLIT = 1'b1
) (
  input  mode_reg_t   cur,
  input  logic [2:0]  wbits,
  output mode_reg_t   nxt
);
  xmode_e req_mode;
  logic   req_split;
  logic   ok;

  always_comb begin
    req_mode  = xmode_e'(wbits[1:0]);
    req_split = HAS_SPLIT ? wbits[2] : 1'b0;
    ok = 1'b1;
    if (req_mode == XM_RSVD)                 ok = 1'b0;
    if (req_mode == XM_SHORT && !HAS_SHORT)  ok = 1'b0;
    if (req_mode == XM_LONG  && !HAS_LONG)   ok = 1'b0;
    if (REJECT_SPLIT && req_split && req_mode != XM_OFF) ok = 1'b0;
    nxt = ok ? mode_reg_t'{split: req_split, mode: req_mode} : cur;
  end
endmodule

// File: rtl/xlat_root_legal.sv
module xlat_root_legal
  import xlat_pkg::*;
#(
  parameter bit HAS_VS39 = 1'b1,
  parameter bit HAS_VS48 = 1'b0,
  parameter int PPN_W    = 28,
  parameter int ASID_W   = 9
) (
  input  xmode_e      mode,
  input  logic [63:0] cur,
  input  logic [63:0] wdata,
  output logic [63:0] nxt
);
  localparam logic [LONG_PPN_W-1:0]  PPN_MASK  = LONG_PPN_W'((41'd1 << PPN_W) - 41'd1);
  localparam logic [LONG_ASID_W-1:0] ASID_MASK = LONG_ASID_W'((17'd1 << ASID_W) - 17'd1);

  vsize_e size;
  logic   size_ok;

  always_comb begin
    size    = vsize_e'(wdata[LONG_SIZE_LO +: 2]);
    size_ok = (size == VS_39 && HAS_VS39) || (size == VS_48 && HAS_VS48);
    if (mode == XM_SHORT) begin
      nxt = {33'd0,
             wdata[SHORT_PPN_W +: SHORT_ASID_W] & ASID_MASK[SHORT_ASID_W-1:0],
             wdata[SHORT_PPN_W-1:0] & PPN_MASK[SHORT_PPN_W-1:0]};
    end else if (size_ok) begin
      nxt = {6'd0, size,
             wdata[LONG_ASID_LO +: LONG_ASID_W] & ASID_MASK,
             wdata[LONG_PPN_W-1:0] & PPN_MASK};
    end else begin
      nxt = cur;
    end
  end
endmodule

// File: rtl/xlat_cfg_decode.sv
module xlat_cfg_decode
  import xlat_pkg::*;
(
  input  xmode_e      mode,
  input  logic [63:0] root,
  output logic        en,
  output logic [39:0] ppn,
  output logic [15:0] asid,
  output logic [2:0]  levels
);
  always_comb begin
    en = 1'b0; ppn = '0; asid = '0; levels = 3'd0;
    unique case (mode)
      XM_SHORT: begin
        en     = 1'b1;
        ppn    = {18'd0, root[SHORT_PPN_W-1:0]};
        asid   = {7'd0, root[SHORT_PPN_W +: SHORT_ASID_W]};
        levels = 3'd2;
      end
      XM_LONG: begin
        en     = 1'b1;
        ppn    = root[LONG_PPN_W-1:0];
        asid   = root[LONG_ASID_LO +: LONG_ASID_W];
        levels = (root[LONG_SIZE_LO +: 2] == VS_48) ? 3'd4 : 3'd3;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xlat_ctl_csr.sv
module xlat_ctl_csr
  import xlat_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter logic [11:0] MODE_ADDR    = 12'h180,
  parameter logic [11:0] ROOT_ADDR    = 12'h181,
  parameter bit          HAS_SHORT    = 1'b1,
  parameter bit          HAS_VS39     = 1'b1,
  parameter bit          HAS_VS48     = 1'b0,
  parameter bit          HAS_SPLIT    = 1'b1,
  parameter bit          REJECT_SPLIT = 1'b1,
  parameter int          PPN_W        = 28,
  parameter int          ASID_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              xlat_en,
  output logic [39:0]       root_ppn,
  output logic [15:0]       asid,
  output logic [2:0]        levels
);
  localparam bit HAS_LONG = HAS_VS39 | HAS_VS48;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mode_reg_t   mode_q, mode_d, mode_legal;
  logic [63:0] root_q, root_d, root_legal;
  logic        sel_mode, sel_root;

  assign sel_mode = (csr_addr == MODE_ADDR[ADDR_W-1:0]);
  assign sel_root = (csr_addr == ROOT_ADDR[ADDR_W-1:0]);

  xlat_mode_legal #(
    .HAS_SHORT(HAS_SHORT), .HAS_LONG(HAS_LONG),
    .HAS_SPLIT(HAS_SPLIT), .REJECT_SPLIT(REJECT_SPLIT)
  ) u_mode_legal (
    .cur(mode_q), .wbits(csr_wdata[2:0]), .nxt(mode_legal)
  );

  xlat_root_legal #(
    .HAS_VS39(HAS_VS39), .HAS_VS48(HAS_VS48), .PPN_W(PPN_W), .ASID_W(ASID_W)
  ) u_root_legal (
    .mode(mode_q.mode), .cur(root_q), .wdata(csr_wdata), .nxt(root_legal)
  );

  always_comb begin
    mode_d = mode_q;
    root_d = root_q;
    if (csr_we && sel_mode) mode_d = mode_legal;
    if (csr_we && sel_root) root_d = root_legal;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= mode_reg_t'('0);
      root_q <= '0;
    end else begin
      mode_q <= mode_d;
      root_q <= root_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (sel_mode)      csr_rdata = {61'd0, mode_q};
    else if (sel_root) csr_rdata = root_q;
  end

  xlat_cfg_decode u_decode (
    .mode(mode_q.mode), .root(root_q),
    .en(xlat_en), .ppn(root_ppn), .asid(asid), .levels(levels)
  );
endmodule

// File: rtl/xlat_ctl_csr_chk.sv
module xlat_ctl_csr_chk #(
  parameter int          ADDR_W       = 12,
  parameter logic [11:0] ROOT_ADDR    = 12'h181,
  parameter bit          HAS_VS39     = 1'b1,
  parameter bit          HAS_VS48     = 1'b0,
  parameter bit          REJECT_SPLIT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [63:0]       csr_wdata,
  input logic [2:0]        mode_bits,
  input logic [63:0]       root_bits,
  input logic              xlat_en,
  input logic [2:0]        levels
);
  logic bad_size;
  assign bad_size = !((csr_wdata[57:56] == 2'd0 && HAS_VS39) ||
                      (csr_wdata[57:56] == 2'd1 && HAS_VS48));

  // R3: reserved mode never stored
  a_r3_no_rsvd_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bits[1:0] != 2'b11);

  // R4: split protection never coexists with paging
  a_r4_split_excl: assert property (@(posedge clk) disable iff (!rst_n)
    REJECT_SPLIT |-> !(mode_bits[2] && mode_bits[1:0] != 2'b00));

  // R6: unsupported size in long layout leaves root untouched
  a_r6_drop_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == ROOT_ADDR[ADDR_W-1:0] && mode_bits[1:0] != 2'b01 && bad_size)
      |=> $stable(root_bits));

  // R7: reserved root bits stay clear
  a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    root_bits[63:58] == 6'd0);

  // R9: levels consistent with enable
  a_r9_levels: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_en ? (levels >= 3'd2 && levels <= 3'd4) : (levels == 3'd0));
endmodule

bind xlat_ctl_csr xlat_ctl_csr_chk #(
  .ADDR_W(ADDR_W), .ROOT_ADDR(ROOT_ADDR), .HAS_VS39(HAS_VS39),
  .HAS_VS48(HAS_VS48), .REJECT_SPLIT(REJECT_SPLIT)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .mode_bits(mode_q), .root_bits(root_q),
  .xlat_en(xlat_en), .levels(levels)
);

// File: tb/xlat_ctl_csr_bench.sv
module xlat_ctl_csr_bench;
  localparam logic [11:0] MA = 12'h180;
  localparam logic [11:0] RA = 12'h181;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = 12'h0;
  logic [63:0] csr_wdata = 64'h0;
  logic [63:0] csr_rdata;
  logic        xlat_en;
  logic [39:0] root_ppn;
  logic [15:0] asid;
  logic [2:0]  levels;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  xlat_ctl_csr u_xlat_ctl_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .xlat_en(xlat_en),
    .root_ppn(root_ppn), .asid(asid), .levels(levels)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0; csr_wdata = 64'h0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    @(negedge clk); csr_addr = a; #1 d = csr_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(MA, v); check("R1 mode", v, 64'h0);
    rd(RA, v); check("R1 root", v, 64'h0);
    check("R1 en", {63'd0, xlat_en}, 64'd0);
    check("R1 levels", {61'd0, levels}, 64'd0);
  endtask

  task automatic t_long;
    logic [63:0] v;
    wr(MA, 64'h2); rd(MA, v); check("R2 long mode", v, 64'h2);
    check("R2 en", {63'd0, xlat_en}, 64'd1);
    wr(RA, 64'hFCFF_FFFF_FFFF_FFFF); rd(RA, v);
    check("R7 masks", v, 64'h0001_FF00_0FFF_FFFF);
    check("R9 levels 3", {61'd0, levels}, 64'd3);
    check("R5 ppn", {24'd0, root_ppn}, 64'h0FFF_FFFF);
    check("R5 asid", {48'd0, asid}, 64'h1FF);
    wr(RA, 64'h0000_0300_0000_0005); rd(RA, v);
    check("R5 small", v, 64'h0000_0300_0000_0005);
  endtask

  task automatic t_bad_size;
    logic [63:0] v;
    wr(RA, 64'h0100_00AA_0000_1234); rd(RA, v);
    check("R6 size1 unbuilt", v, 64'h0000_0300_0000_0005);
    wr(RA, 64'h0200_0000_0000_0777); rd(RA, v);
    check("R6 size2", v, 64'h0000_0300_0000_0005);
    wr(RA, 64'h0300_0011_0000_0999); rd(RA, v);
    check("R6 size3", v, 64'h0000_0300_0000_0005);
  endtask

  task automatic t_mode_legal;
    logic [63:0] v;
    wr(MA, 64'h3); rd(MA, v); check("R3 rsvd mode", v, 64'h2);
    wr(MA, 64'h5); rd(MA, v); check("R4 split+short", v, 64'h2);
    wr(MA, 64'h6); rd(MA, v); check("R4 split+long", v, 64'h2);
    wr(MA, 64'hFFFF_FFFF_FFFF_FFF4); rd(MA, v); check("R4 split off ok", v, 64'h4);
    check("R9 off en", {63'd0, xlat_en}, 64'd0);
    check("R9 off levels", {61'd0, levels}, 64'd0);
    check("R9 off ppn", {24'd0, root_ppn}, 64'd0);
  endtask

  task automatic t_short;
    logic [63:0] v;
    wr(MA, 64'h1); rd(MA, v); check("R2 short mode", v, 64'h1);
    check("R9 levels 2", {61'd0, levels}, 64'd2);
    wr(RA, 64'hFFFF_FFFF_FFFF_FFFF); rd(RA, v);
    check("R8 short store", v, 64'h7FFF_FFFF);
    check("R8 ppn", {24'd0, root_ppn}, 64'h3F_FFFF);
    check("R8 asid", {48'd0, asid}, 64'h1FF);
  endtask

  task automatic t_idle;
    logic [63:0] v;
    @(negedge clk); csr_addr = RA; csr_wdata = 64'h0; csr_we = 1'b0;
    @(negedge clk); rd(RA, v); check("R10 no we", v, 64'h7FFF_FFFF);
    rd(12'h0, v); check("R10 other addr", v, 64'h0);
    wr(12'h0, 64'hFFFF); rd(MA, v); check("R10 stray write", v, 64'h1);
  endtask

  initial begin
    #10000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_long;
    t_bad_size;
    t_mode_legal;
    t_short;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule